// File: doc/BRIEF.md
# Duplicate-Cancelling Best-Two Track Sorter

Each clock cycle the block receives one event made of twelve candidate track words. A slot number identifies where each candidate came from, and neighbouring slots cover neighbouring sectors. A particle that crosses a sector boundary can be reconstructed by both neighbours from the same segment, which gives two copies of one track. The block first removes such copies by comparing segment addresses in adjacent slots. From the candidates that remain, it selects the two with the highest rank. These are driven out as a first and a second output track, each with a valid flag.

The selection is fully parallel. One comparator exists for every unordered pair of slots. Equations over the comparator outcomes then give one-hot selection vectors for the first and the second place, with no serial passes. The block has two register stages, one on the inputs and one on the outputs. It accepts a new event every cycle.

Top module: `trk_best2_sorter`

## Requirements
- R1: The rank of a track is the unsigned value of word bits 30..23: the quality field (bits 30..28) forms the upper part and transverse momentum (bits 27..23) the lower part. The first output carries the eligible track with the highest rank.
- R2: When ranks are equal, the lower slot index wins. This applies to both the first and the second place.
- R3: The second output carries the eligible track with the highest rank among all eligible tracks other than the first. Its rank never exceeds the rank of the first output.
- R4: A track whose input valid flag is low is never selected, whatever its word contains.
- R5: Slots i and i+1 form an adjacent pair; slots 0 and N_TRK-1 are not adjacent. If both tracks of an adjacent pair are valid and their segment address fields (bits 6..0) are equal and non-zero, the track with the lower quality (bits 30..28) is cancelled. Each pair is judged on the input flags alone, so a track that is cancelled in one pair still cancels its neighbour in another pair.
- R6: When a duplicate pair has equal quality, the track in the higher-numbered slot is cancelled.
- R7: Tracks in non-adjacent slots, and tracks whose segment address is zero, are never cancelled as duplicates.
- R8: An output with no eligible candidate drives an all-zero word and a low valid flag. The second output is valid only when the first output is valid.
- R9: An event presented at clock edge k appears on the outputs after edge k+1. Events may arrive on consecutive cycles. If any input of an event is valid, the first output for that event is valid.
- R10: Reset is synchronous and active low. After an edge with reset asserted, both outputs are zero and both valid flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| i_trk | input | N_TRK×31 | Candidate track words; element i belongs to slot i |
| i_vld | input | N_TRK | Valid flag for each slot |
| o_trk0 | output | 31 | Highest-ranked surviving track |
| o_vld0 | output | 1 | First output valid |
| o_trk1 | output | 31 | Second-ranked surviving track |
| o_vld1 | output | 1 | Second output valid |

## Verification
The assertions assume that reset is held for at least one edge. Their two-cycle latency check also assumes that the input valid flags are defined on every edge after reset, including idle cycles. The bench meets both assumptions. It drives every input on the falling edge and holds reset low while it loads non-zero words, and on idle cycles it sets all valid flags low rather than leaving them undefined. The sweep draws segment addresses from only four values and limits quality to two values on every third event. As a result, adjacent duplicates, quality ties and chained cancellations occur often, and a directed set of cases covers the slot-boundary and zero-address cases.

// File: rtl/trksort_pkg.sv
// Package trksort_pkg
// Field positions of the 31-bit track word and widths shared by the sorter.
// Assumes the track layout is fixed; only the slot count is a parameter.
package trksort_pkg;
    localparam int TRK_W   = 31;
    localparam int QUAL_HI = 30;
    localparam int QUAL_LO = 28;
    localparam int RANK_HI = 30;
    localparam int RANK_LO = 23;
    localparam int ADDR_HI = 6;
    localparam int ADDR_LO = 0;
    localparam int RANK_W  = RANK_HI - RANK_LO + 1;
    localparam int ADDR_W  = ADDR_HI - ADDR_LO + 1;
    localparam int QUAL_W  = QUAL_HI - QUAL_LO + 1;
endpackage

// File: rtl/trk_dup_cancel.sv
// Module trk_dup_cancel
// Marks which slots stay eligible once duplicate candidates are removed.
// Adjacent slots that share a non-zero segment address lose their lower-quality
// member; on a quality tie the higher slot loses. Each pair is judged on the
// raw valid flags only. Assumes N_TRK >= 2.
module trk_dup_cancel
    import trksort_pkg::*;
#(
    parameter int N_TRK = 12
) (
    input  logic [N_TRK-1:0][TRK_W-1:0] trk,
    input  logic [N_TRK-1:0]            vld,
    output logic [N_TRK-1:0]            keep
);
    localparam int N_PAIR = N_TRK - 1;

    logic [N_PAIR-1:0] kill_lo;
    logic [N_PAIR-1:0] kill_hi;

    // One duplicate detector per adjacent slot pair.
    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
        logic [ADDR_W-1:0] addr_a;
        logic [ADDR_W-1:0] addr_b;
        logic              shared;
        logic              hi_loses;
        assign addr_a   = trk[p][ADDR_HI:ADDR_LO];
        assign addr_b   = trk[p+1][ADDR_HI:ADDR_LO];
        assign shared   = vld[p] & vld[p+1] & (addr_a == addr_b) & (addr_a != '0);
        assign hi_loses = trk[p+1][QUAL_HI:QUAL_LO] <= trk[p][QUAL_HI:QUAL_LO];
        assign kill_lo[p] = shared & ~hi_loses;
        assign kill_hi[p] = shared & hi_loses;
    end

    // Each slot combines the verdicts of the pair above it and the pair below it.
    for (genvar i = 0; i < N_TRK; i++) begin : g_slot
        logic from_up;
        logic from_dn;
        if (i < N_PAIR) begin : g_up
            assign from_up = kill_lo[i];
        end else begin : g_no_up
            assign from_up = 1'b0;
        end
        if (i > 0) begin : g_dn
            assign from_dn = kill_hi[i-1];
        end else begin : g_no_dn
            assign from_dn = 1'b0;
        end
        assign keep[i] = vld[i] & ~from_up & ~from_dn;
    end
endmodule

// File: rtl/trk_rank_matrix.sv
// Module trk_rank_matrix
// Full pairwise comparator matrix over the slot keys {eligible, rank}, followed
// by selection equations. A slot that loses to nobody is first; a slot that
// loses to exactly one other slot is second. Ties go to the lower index, so
// the comparison defines a strict total order and both vectors are one-hot or
// zero. Ineligible slots can never beat an eligible one.
module trk_rank_matrix
    import trksort_pkg::*;
#(
    parameter int N_TRK = 12
) (
    input  logic [N_TRK-1:0][TRK_W-1:0] trk,
    input  logic [N_TRK-1:0]            keep,
    output logic [N_TRK-1:0]            sel1,
    output logic [N_TRK-1:0]            sel2
);
    localparam int KEY_W = RANK_W + 1;
    localparam int CNT_W = $clog2(N_TRK) + 1;

    logic [KEY_W-1:0] key   [N_TRK];
    logic             beats [N_TRK][N_TRK];
    logic [CNT_W-1:0] lost  [N_TRK];

    // Sort key: eligibility above the 8-bit rank.
    for (genvar i = 0; i < N_TRK; i++) begin : g_key
        assign key[i] = {keep[i], trk[i][RANK_HI:RANK_LO]};
    end

    // One comparator per unordered pair; the mirrored entry is its complement.
    for (genvar i = 0; i < N_TRK; i++) begin : g_row
        for (genvar j = 0; j < N_TRK; j++) begin : g_col
            if (i < j) begin : g_cmp
                assign beats[i][j] = key[i] >= key[j];
            end else if (i > j) begin : g_mirror
                assign beats[i][j] = ~beats[j][i];
            end else begin : g_diag
                assign beats[i][j] = 1'b0;
            end
        end
    end

    // Selection equations: count the defeats of each slot and decode places one and two.
    always_comb begin
        for (int i = 0; i < N_TRK; i++) begin
            lost[i] = '0;
            for (int j = 0; j < N_TRK; j++) begin
                if (j != i && !beats[i][j]) begin
                    lost[i] = lost[i] + CNT_W'(1);
                end
            end
            sel1[i] = keep[i] && (lost[i] == CNT_W'(0));
            sel2[i] = keep[i] && (lost[i] == CNT_W'(1));
        end
    end
endmodule

// File: rtl/trk_out_mux.sv
// Module trk_out_mux
// AND-OR multiplexer that forwards the track named by a one-hot select vector.
// Assumes sel is one-hot or zero; an all-zero select yields a zero word and hit low.
module trk_out_mux
    import trksort_pkg::*;
#(
    parameter int N_TRK = 12
) (
    input  logic [N_TRK-1:0][TRK_W-1:0] trk,
    input  logic [N_TRK-1:0]            sel,
    output logic [TRK_W-1:0]            word,
    output logic                        hit
);
    // Merge the masked slot words.
    always_comb begin
        word = '0;
        for (int i = 0; i < N_TRK; i++) begin
            word = word | (trk[i] & {TRK_W{sel[i]}});
        end
    end

    // The output is valid whenever any slot is selected.
    assign hit = |sel;
endmodule

// File: rtl/trk_best2_sorter.sv
// Module trk_best2_sorter
// Top level: registers one event of N_TRK track words, cancels adjacent-slot
// duplicates, picks the best two survivors through a parallel comparator
// matrix, and registers the two results. Latency is two edges and a new event
// may be presented every cycle. Reset is synchronous and active low.
module trk_best2_sorter
    import trksort_pkg::*;
#(
    parameter int N_TRK = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_TRK-1:0][TRK_W-1:0] i_trk,
    input  logic [N_TRK-1:0]            i_vld,
    output logic [TRK_W-1:0]            o_trk0,
    output logic                        o_vld0,
    output logic [TRK_W-1:0]            o_trk1,
    output logic                        o_vld1
);
    logic [N_TRK-1:0][TRK_W-1:0] r_trk;
    logic [N_TRK-1:0]            r_vld;
    logic [N_TRK-1:0]            keep;
    logic [N_TRK-1:0]            sel1;
    logic [N_TRK-1:0]            sel2;
    logic [TRK_W-1:0]            pick0;
    logic [TRK_W-1:0]            pick1;
    logic                        hit0;
    logic                        hit1;

    // Stage 1: capture the incoming event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_trk <= '0;
            r_vld <= '0;
        end else begin
            r_trk <= i_trk;
            r_vld <= i_vld;
        end
    end

    trk_dup_cancel #(.N_TRK(N_TRK)) u_cancel (
        .trk  (r_trk),
        .vld  (r_vld),
        .keep (keep)
    );

    trk_rank_matrix #(.N_TRK(N_TRK)) u_matrix (
        .trk  (r_trk),
        .keep (keep),
        .sel1 (sel1),
        .sel2 (sel2)
    );

    trk_out_mux #(.N_TRK(N_TRK)) u_mux0 (
        .trk  (r_trk),
        .sel  (sel1),
        .word (pick0),
        .hit  (hit0)
    );

    trk_out_mux #(.N_TRK(N_TRK)) u_mux1 (
        .trk  (r_trk),
        .sel  (sel2),
        .word (pick1),
        .hit  (hit1)
    );

    // Stage 2: register both selected tracks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_trk0 <= '0;
            o_vld0 <= 1'b0;
            o_trk1 <= '0;
            o_vld1 <= 1'b0;
        end else begin
            o_trk0 <= pick0;
            o_vld0 <= hit0;
            o_trk1 <= pick1;
            o_vld1 <= hit1;
        end
    end
endmodule

// File: rtl/trk_best2_sorter_chk.sv
// Module trk_best2_sorter_chk
// Port-level properties of the sorter, attached by bind. Assumes reset is held
// for at least one edge and that i_vld is defined on every edge after reset.
module trk_best2_sorter_chk
    import trksort_pkg::*;
#(
    parameter int N_TRK = 12
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [N_TRK-1:0][TRK_W-1:0] i_trk,
    input logic [N_TRK-1:0]            i_vld,
    input logic [TRK_W-1:0]            o_trk0,
    input logic                        o_vld0,
    input logic [TRK_W-1:0]            o_trk1,
    input logic                        o_vld1
);
    logic [1:0] cyc;

    // Count the edges since reset, saturating, to guard two-cycle look-backs.
    always_ff @(posedge clk) begin
        if (!rst_n)          cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    a_r3_rank_order: assert property (@(posedge clk) disable iff (!rst_n)
        o_vld1 |-> (o_trk0[RANK_HI:RANK_LO] >= o_trk1[RANK_HI:RANK_LO]));

    a_r8_second_needs_first: assert property (@(posedge clk) disable iff (!rst_n)
        o_vld1 |-> o_vld0);

    a_r8_empty0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !o_vld0 |-> (o_trk0 == '0));

    a_r8_empty1_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !o_vld1 |-> (o_trk1 == '0));

    a_r9_two_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> (o_vld0 == ($past(i_vld, 2) != '0)));

    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!o_vld0 && !o_vld1 && o_trk0 == '0 && o_trk1 == '0));
endmodule

bind trk_best2_sorter trk_best2_sorter_chk #(.N_TRK(N_TRK)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .i_trk  (i_trk),
    .i_vld  (i_vld),
    .o_trk0 (o_trk0),
    .o_vld0 (o_vld0),
    .o_trk1 (o_trk1),
    .o_vld1 (o_vld1)
);

// File: tb/test_trk_best2_sorter.sv
// Bench for trk_best2_sorter: directed corner cases plus a broad pseudo-random
// sweep. Expected outputs come from a sequential reference model.
module test_trk_best2_sorter;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 12;
    localparam int W          = 31;
    localparam int N_RAND     = 4000;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [N-1:0][W-1:0] i_trk;
    logic [N-1:0]        i_vld;
    logic [W-1:0]        o_trk0;
    logic                o_vld0;
    logic [W-1:0]        o_trk1;
    logic                o_vld1;

    int          n_chk  = 0;
    int          n_fail = 0;
    logic [31:0] seed   = 32'h1234_5678;

    logic [W-1:0] tw [N];
    logic         tv [N];
    logic [W-1:0] e0, e1;
    logic         ev0, ev1;

    trk_best2_sorter #(.N_TRK(N)) i_trk_best2_sorter (
        .clk(clk), .rst_n(rst_n), .i_trk(i_trk), .i_vld(i_vld),
        .o_trk0(o_trk0), .o_vld0(o_vld0), .o_trk1(o_trk1), .o_vld1(o_vld1)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    function automatic logic [W-1:0] mk(input logic [2:0] q, input logic [4:0] pt,
                                        input logic [6:0] addr, input logic [15:0] fill);
        return {q, pt, fill[0], fill[8:1], fill[15:9], addr};
    endfunction

    task automatic clear_event();
        for (int i = 0; i < N; i++) begin
            tw[i] = '0;
            tv[i] = 1'b0;
        end
    endtask

    task automatic drive();
        for (int i = 0; i < N; i++) begin
            i_trk[i] = tw[i];
            i_vld[i] = tv[i];
        end
    endtask

    // Reference: cancel duplicates, then a linear scan for the two best.
    task automatic model();
        logic can [N];
        int   b1, b2;
        for (int i = 0; i < N; i++) can[i] = 1'b0;
        for (int p = 0; p < N - 1; p++) begin
            if (tv[p] && tv[p+1] && tw[p][6:0] == tw[p+1][6:0] && tw[p][6:0] != 0) begin
                if (tw[p+1][30:28] <= tw[p][30:28]) can[p+1] = 1'b1;
                else                                 can[p]   = 1'b1;
            end
        end
        b1 = -1;
        for (int i = 0; i < N; i++)
            if (tv[i] && !can[i] && (b1 < 0 || tw[i][30:23] > tw[b1][30:23])) b1 = i;
        b2 = -1;
        for (int i = 0; i < N; i++)
            if (i != b1 && tv[i] && !can[i] && (b2 < 0 || tw[i][30:23] > tw[b2][30:23])) b2 = i;
        e0  = (b1 >= 0) ? tw[b1] : '0;
        ev0 = (b1 >= 0);
        e1  = (b2 >= 0) ? tw[b2] : '0;
        ev1 = (b2 >= 0);
    endtask

    task automatic compare(input string tag);
        n_chk++;
        if (o_trk0 !== e0 || o_vld0 !== ev0) begin
            n_fail++;
            $display("FAIL %s out0: actual=%h/%b expected=%h/%b", tag, o_trk0, o_vld0, e0, ev0);
        end
        n_chk++;
        if (o_trk1 !== e1 || o_vld1 !== ev1) begin
            n_fail++;
            $display("FAIL %s out1: actual=%h/%b expected=%h/%b", tag, o_trk1, o_vld1, e1, ev1);
        end
    endtask

    // Present the event at a falling edge, wait two rising edges, then sample.
    task automatic run_event(input string tag);
        drive();
        model();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic rand_event(input int k);
        for (int i = 0; i < N; i++) begin
            seed = nxt(seed);
            tw[i] = mk((k % 3 == 0) ? {2'b01, seed[0]} : seed[2:0], seed[7:3],
                       {5'd0, seed[9:8]}, seed[27:12]);
            tv[i] = (seed[11:10] != 2'b00);
        end
    endtask

    initial begin
        // R10: outputs stay clear while reset is held with live inputs.
        rst_n = 1'b0;
        rand_event(1);
        drive();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        e0 = '0; e1 = '0; ev0 = 1'b0; ev1 = 1'b0;
        compare("R10 reset");
        rst_n = 1'b1;

        // R4 R8: non-zero words with every flag low.
        for (int i = 0; i < N; i++) begin
            tw[i] = mk(3'd7, 5'd31, 7'd9, 16'hBEEF);
            tv[i] = 1'b0;
        end
        run_event("R4 R8 all invalid");

        // R8: a single valid track at the top slot.
        tv[N-1] = 1'b1;
        run_event("R8 single candidate");

        // R2 R7: equal ranks with zero addresses are all kept.
        for (int i = 0; i < N; i++) begin
            tw[i] = mk(3'd5, 5'd10, 7'd0, 16'(i * 77));
            tv[i] = 1'b1;
        end
        run_event("R2 R7 equal rank ties");

        // R6: equal-quality duplicate cancels the higher slot despite its higher pt.
        clear_event();
        tw[4] = mk(3'd6, 5'd3, 7'd5, 16'h0101); tv[4] = 1'b1;
        tw[5] = mk(3'd6, 5'd30, 7'd5, 16'h0202); tv[5] = 1'b1;
        tw[9] = mk(3'd2, 5'd1, 7'd5, 16'h0303); tv[9] = 1'b1;
        run_event("R6 quality tie");

        // R5: lower quality in the lower slot is cancelled.
        clear_event();
        tw[2] = mk(3'd3, 5'd31, 7'd17, 16'h1111); tv[2] = 1'b1;
        tw[3] = mk(3'd5, 5'd0, 7'd17, 16'h2222); tv[3] = 1'b1;
        tw[7] = mk(3'd1, 5'd2, 7'd17, 16'h3333); tv[7] = 1'b1;
        run_event("R5 lower quality cancelled");

        // R7: same address in slots 0 and N-1, and in slots 3 and 5.
        clear_event();
        tw[0]   = mk(3'd4, 5'd1, 7'd33, 16'h4444); tv[0]   = 1'b1;
        tw[N-1] = mk(3'd4, 5'd9, 7'd33, 16'h5555); tv[N-1] = 1'b1;
        tw[3]   = mk(3'd2, 5'd1, 7'd33, 16'h6666); tv[3]   = 1'b1;
        tw[5]   = mk(3'd2, 5'd2, 7'd33, 16'h7777); tv[5]   = 1'b1;
        run_event("R7 non-adjacent kept");

        // R5: rising-quality chain; only the top of the chain survives.
        clear_event();
        tw[6] = mk(3'd2, 5'd31, 7'd44, 16'h0a0a); tv[6] = 1'b1;
        tw[7] = mk(3'd5, 5'd31, 7'd44, 16'h0b0b); tv[7] = 1'b1;
        tw[8] = mk(3'd7, 5'd0, 7'd44, 16'h0c0c); tv[8] = 1'b1;
        tw[1] = mk(3'd1, 5'd1, 7'd0, 16'h0d0d);  tv[1] = 1'b1;
        run_event("R5 chained pairs");

        // R9: back-to-back events, each checked two edges after it is presented.
        begin
            logic [W-1:0] a0, a1;
            logic         av0, av1;
            rand_event(2);
            drive();
            model();
            a0 = e0; a1 = e1; av0 = ev0; av1 = ev1;
            @(posedge clk);
            @(negedge clk);
            rand_event(4);
            drive();
            model();
            @(posedge clk);
            @(negedge clk);
            begin
                logic [W-1:0] b0, b1;
                logic         bv0, bv1;
                b0 = e0; b1 = e1; bv0 = ev0; bv1 = ev1;
                e0 = a0; e1 = a1; ev0 = av0; ev1 = av1;
                compare("R9 stream first");
                clear_event();
                drive();
                @(posedge clk);
                @(negedge clk);
                e0 = b0; e1 = b1; ev0 = bv0; ev1 = bv1;
                compare("R9 stream second");
            end
        end

        // R1 R2 R3 R5 R6 R7: broad sweep with frequent duplicates and ties.
        for (int k = 0; k < N_RAND; k++) begin
            rand_event(k);
            run_event("R1 R3 sweep");
        end

        // R10: reset in the middle of traffic clears the pipeline.
        rand_event(5);
        tv[0] = 1'b1;
        drive();
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        e0 = '0; e1 = '0; ev0 = 1'b0; ev1 = 1'b0;
        compare("R10 mid-run reset");
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule